// File: doc/BRIEF.md
# Sixteen-bit single-cycle RISC core

The core completes one instruction per clock. A 16-bit instruction word is fetched from an internal instruction array at the current program counter. It is decoded from its top four bits, and its effect is committed at the next rising edge. That effect is a register write, a data-RAM write or a change of flow. The core holds eight 16-bit general registers with two combinational read ports and one write port. A combinational ALU has its own operation decoder. The data RAM is word-addressed, with one combinational read port.

The program counter counts bytes, so sequential instructions sit two addresses apart. Both internal arrays are filled through a preload port. The preload port works whether or not the core is in reset, so a test harness can load a program and its data, release reset, and follow execution on the debug outputs. Those outputs show the program counter and the register write port.

Top module: `risc16_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0x0000 and all eight registers become zero. While `rst` is high, `dbg_wr_en` is 0 and no store reaches the data RAM.
- R2: A non-jump instruction advances the program counter by 2 at the next edge. The instruction executed is the instruction-array word at index (PC / 2) modulo IMEM_WORDS. Bit 0 of the program counter is always 0.
- R3: Opcode 0x0 (load) has base register [11:9], destination register [8:6] and offset [5:0]. The offset is sign-extended to 16 bits and added to the base. The destination receives the data-RAM word at that sum modulo DMEM_WORDS.
- R4: Opcode 0x1 (store) has base register [11:9], source register [8:6] and offset [5:0], with the address formed as in R3. The source value is written to that data-RAM word at the edge. No register is written.
- R5: Opcodes 0x2 (add), 0x3 (subtract A minus B) and 0x4 (bitwise and) take A from [11:9] and B from [8:6], and write the result to register [5:3]. Results wrap modulo 2^16. Register 0 is an ordinary register.
- R6: Opcode 0xD (jump) loads the program counter with {(PC+2)[15:13], instr[11:0], 0}. No register is written.
- R7: Any other opcode writes no register and no memory, and advances the program counter by 2.
- R8: Reset leaves the contents of both arrays unchanged.
- R9: A preload with `pl_en`=1 writes `pl_data` at the next edge. It goes to data-RAM word `pl_addr` when `pl_dmem`=1, or to instruction word `pl_addr` modulo IMEM_WORDS when `pl_dmem`=0. If a preload and a store hit the same data-RAM word in one cycle, the preload value is kept. If they hit different words, both are written.
- R10: In each cycle where an instruction writes a register, `dbg_wr_en` is 1 and `dbg_wr_addr`/`dbg_wr_data` show the target and the value committed at the next edge. Otherwise `dbg_wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pl_en | input | 1 | Preload write strobe |
| pl_dmem | input | 1 | Preload target: 1 data RAM, 0 instruction array |
| pl_addr | input | DAW | Preload word index |
| pl_data | input | 16 | Preload word |
| dbg_pc | output | 16 | Current program counter (byte address) |
| dbg_wr_en | output | 1 | Register write active this cycle |
| dbg_wr_addr | output | 3 | Register being written |
| dbg_wr_data | output | 16 | Value being written |

## Verification
Two data-RAM writers can act in the same cycle: a store instruction and a preload. The bench releases reset with a store to word 9 already at address 0 and drives a preload to the same word in that same cycle. A following load must return the preload value. Later, a store to word 10 is paired with a preload to word 11, and the two following loads must return the stored zero and the preloaded word.

// File: rtl/risc16_pkg.sv
package risc16_pkg;

  localparam int XLEN = 16;

  typedef enum logic [3:0] {
    OP_LD  = 4'h0,
    OP_ST  = 4'h1,
    OP_ADD = 4'h2,
    OP_SUB = 4'h3,
    OP_AND = 4'h4,
    OP_JMP = 4'hD
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic reg_we;     // instruction writes a register
    logic mem_we;     // instruction writes data RAM
    logic mem_rd;     // register data comes from data RAM
    logic use_imm;    // ALU B operand is the offset
    logic dst_low;    // destination field at [5:3] instead of [8:6]
    logic jump;       // change of flow
    logic known;      // opcode is defined
  } ctrl_t;

  // offset widening
  function automatic logic [XLEN-1:0] sext6(input logic [5:0] off);
    return {{(XLEN-6){off[5]}}, off};
  endfunction

  // sequential successor of a byte-stepped PC
  function automatic logic [XLEN-1:0] seq_pc(input logic [XLEN-1:0] pc);
    return pc + XLEN'(2);
  endfunction

  // jump destination: page bits from the successor, field, even byte
  function automatic logic [XLEN-1:0] jump_pc(input logic [XLEN-1:0] pc,
                                              input logic [11:0] field);
    logic [XLEN-1:0] nxt;
    nxt = seq_pc(pc);
    return {nxt[XLEN-1:13], field, 1'b0};
  endfunction

  // ALU operation selection from opcode
  function automatic alu_op_e alu_sel(input logic [3:0] op);
    case (op)
      OP_SUB:  return ALU_SUB;
      OP_AND:  return ALU_AND;
      default: return ALU_ADD;
    endcase
  endfunction

endpackage

// File: rtl/risc16_decoder.sv
module risc16_decoder
  import risc16_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl,
  output alu_op_e    alu_op
);

  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_LD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.mem_rd  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.known   = 1'b1;
      end
      OP_ST: begin
        ctrl.mem_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.known   = 1'b1;
      end
      OP_ADD, OP_SUB, OP_AND: begin
        ctrl.reg_we  = 1'b1;
        ctrl.dst_low = 1'b1;
        ctrl.known   = 1'b1;
      end
      OP_JMP: begin
        ctrl.jump    = 1'b1;
        ctrl.known   = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  assign alu_op = alu_sel(opcode);

endmodule

// File: rtl/risc16_alu.sv
module risc16_alu
  import risc16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/risc16_regfile.sv
module risc16_regfile #(
  parameter int W     = 16,
  parameter int NREG  = 8,
  localparam int RAW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  output logic [W-1:0]   rd1,
  output logic [W-1:0]   rd2,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [W-1:0]   wd
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

endmodule

// File: rtl/risc16_mem.sv
module risc16_mem #(
  parameter int W      = 16,
  parameter int WORDS  = 256,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [W-1:0]  core_wd,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [W-1:0]  pl_wd,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [WORDS];
  logic         core_blocked;

  // preload owns the word when both writers hit it
  assign core_blocked = pl_we && (pl_addr == core_addr);

  always_ff @(posedge clk) begin
    if (core_we && !core_blocked) mem[core_addr] <= core_wd;
    if (pl_we) mem[pl_addr] <= pl_wd;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/risc16_core.sv
module risc16_core
  import risc16_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 256,
  parameter int NREG       = 8,
  localparam int IAW       = $clog2(IMEM_WORDS),
  localparam int DAW       = $clog2(DMEM_WORDS),
  localparam int RAW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pl_en,
  input  logic            pl_dmem,
  input  logic [DAW-1:0]  pl_addr,
  input  logic [XLEN-1:0] pl_data,
  output logic [XLEN-1:0] dbg_pc,
  output logic            dbg_wr_en,
  output logic [RAW-1:0]  dbg_wr_addr,
  output logic [XLEN-1:0] dbg_wr_data
);

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] pc_seq;
  logic [XLEN-1:0] pc_next;
  logic [XLEN-1:0] instr;
  ctrl_t           ctrl;
  alu_op_e         alu_op;
  logic [XLEN-1:0] rd_a, rd_b, alu_b, alu_y, dmem_q;
  logic [RAW-1:0]  fa, fb, fd;

  // named events for the checker
  logic is_jump, is_store, is_known, rf_we, store_we;

  // fetch
  risc16_mem #(.W(XLEN), .WORDS(IMEM_WORDS)) u_imem (
    .clk       (clk),
    .core_we   (1'b0),
    .core_addr ('0),
    .core_wd   ('0),
    .pl_we     (pl_en && !pl_dmem),
    .pl_addr   (pl_addr[IAW-1:0]),
    .pl_wd     (pl_data),
    .raddr     (pc[IAW:1]),
    .rdata     (instr)
  );

  risc16_decoder u_dec (
    .opcode (instr[15:12]),
    .ctrl   (ctrl),
    .alu_op (alu_op)
  );

  assign fa = instr[11:9];
  assign fb = instr[8:6];
  assign fd = ctrl.dst_low ? instr[5:3] : instr[8:6];

  risc16_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (fa),
    .ra2 (fb),
    .rd1 (rd_a),
    .rd2 (rd_b),
    .we  (rf_we),
    .wa  (fd),
    .wd  (dbg_wr_data)
  );

  assign alu_b = ctrl.use_imm ? sext6(instr[5:0]) : rd_b;

  risc16_alu #(.W(XLEN)) u_alu (
    .op (alu_op),
    .a  (rd_a),
    .b  (alu_b),
    .y  (alu_y)
  );

  risc16_mem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk       (clk),
    .core_we   (store_we),
    .core_addr (alu_y[DAW-1:0]),
    .core_wd   (rd_b),
    .pl_we     (pl_en && pl_dmem),
    .pl_addr   (pl_addr),
    .pl_wd     (pl_data),
    .raddr     (alu_y[DAW-1:0]),
    .rdata     (dmem_q)
  );

  assign is_jump  = ctrl.jump;
  assign is_store = ctrl.mem_we;
  assign is_known = ctrl.known;
  assign rf_we    = ctrl.reg_we && !rst;
  assign store_we = ctrl.mem_we && !rst;

  assign pc_seq  = seq_pc(pc);
  assign pc_next = ctrl.jump ? jump_pc(pc, instr[11:0]) : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign dbg_pc      = pc;
  assign dbg_wr_en   = rf_we;
  assign dbg_wr_addr = fd;
  assign dbg_wr_data = ctrl.mem_rd ? dmem_q : alu_y;

endmodule

// File: rtl/risc16_core_chk.sv
module risc16_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] dbg_pc,
  input logic        dbg_wr_en,
  input logic [15:0] pc_seq,
  input logic        is_jump,
  input logic        is_store,
  input logic        is_known
);

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> dbg_pc == 16'h0000);

  // R1
  no_write_in_reset_chk: assert property (@(posedge clk) rst |-> !dbg_wr_en);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !is_jump |=> dbg_pc == $past(dbg_pc) + 16'd2);

  // R2
  pc_even_chk: assert property (@(posedge clk) disable iff (rst) dbg_pc[0] == 1'b0);

  // R6
  jump_page_chk: assert property (@(posedge clk) disable iff (rst)
    is_jump |=> dbg_pc[15:13] == $past(pc_seq[15:13]));

  // R4
  store_no_rf_chk: assert property (@(posedge clk) disable iff (rst)
    is_store |-> !dbg_wr_en);

  // R6
  jump_no_rf_chk: assert property (@(posedge clk) disable iff (rst)
    is_jump |-> !dbg_wr_en);

  // R7
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !is_known |-> !dbg_wr_en);

endmodule

bind risc16_core risc16_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .dbg_pc    (dbg_pc),
  .dbg_wr_en (dbg_wr_en),
  .pc_seq    (pc_seq),
  .is_jump   (is_jump),
  .is_store  (is_store),
  .is_known  (is_known)
);

// File: tb/risc16_core_test.sv
module risc16_core_test;

  localparam int IMW = 64;
  localparam int DMW = 256;
  localparam int DAW = $clog2(DMW);
  localparam int NROW = 16;

  // row: pc, instr, expected write enable, address, data
  localparam logic [51:0] PROG [NROW] = '{
    {16'h0000, 16'h0040, 1'b1, 3'd1, 16'h0001},
    {16'h0002, 16'h0081, 1'b1, 3'd2, 16'h0005},
    {16'h0004, 16'h2298, 1'b1, 3'd3, 16'h0006},
    {16'h0006, 16'h3460, 1'b1, 3'd4, 16'h0004},
    {16'h0008, 16'h4728, 1'b1, 3'd5, 16'h0004},
    {16'h000A, 16'h01BF, 1'b1, 3'd6, 16'h8000},
    {16'h000C, 16'h14C3, 1'b0, 3'd0, 16'h0000},
    {16'h000E, 16'h03C7, 1'b1, 3'd7, 16'h0006},
    {16'h0010, 16'h2D80, 1'b1, 3'd0, 16'h0000},
    {16'h0012, 16'h19FE, 1'b0, 3'd0, 16'h0000},
    {16'h0014, 16'h0042, 1'b1, 3'd1, 16'h0006},
    {16'h0016, 16'hF000, 1'b0, 3'd0, 16'h0000},
    {16'h0018, 16'hD010, 1'b0, 3'd0, 16'h0000},
    {16'h0020, 16'h2250, 1'b1, 3'd2, 16'h000C},
    {16'h0022, 16'hD011, 1'b0, 3'd0, 16'h0000},
    {16'h0022, 16'hD011, 1'b0, 3'd0, 16'h0000}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           pl_en = 1'b0;
  logic           pl_dmem = 1'b0;
  logic [DAW-1:0] pl_addr = '0;
  logic [15:0]    pl_data = '0;
  logic [15:0]    dbg_pc;
  logic           dbg_wr_en;
  logic [2:0]     dbg_wr_addr;
  logic [15:0]    dbg_wr_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  risc16_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) uut (
    .clk (clk), .rst (rst),
    .pl_en (pl_en), .pl_dmem (pl_dmem), .pl_addr (pl_addr), .pl_data (pl_data),
    .dbg_pc (dbg_pc), .dbg_wr_en (dbg_wr_en),
    .dbg_wr_addr (dbg_wr_addr), .dbg_wr_data (dbg_wr_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of expected debug outputs
  task automatic chk_cyc(input string req, input logic [15:0] pc, input logic en,
                         input logic [2:0] a, input logic [15:0] d);
    chk({req, " pc"}, dbg_pc, pc);
    chk({req, " wr_en"}, {15'd0, dbg_wr_en}, {15'd0, en});
    if (en) begin
      chk({req, " wr_addr"}, {13'd0, dbg_wr_addr}, {13'd0, a});
      chk({req, " wr_data"}, dbg_wr_data, d);
    end
  endtask

  task automatic preload(input logic sel, input int addr, input logic [15:0] data);
    @(negedge clk);
    pl_en = 1'b1; pl_dmem = sel; pl_addr = DAW'(addr); pl_data = data;
    @(posedge clk);
    #1 pl_en = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 reset pc", dbg_pc, 16'h0000);
    chk("R1 reset wr_en", {15'd0, dbg_wr_en}, 16'h0000);

    preload(1'b1, 0, 16'h0001);
    preload(1'b1, 1, 16'h0005);
    preload(1'b1, 255, 16'h8000);
    for (int i = 0; i < NROW; i++) preload(1'b0, int'(PROG[i][51:36] >> 1), PROG[i][35:20]);
    preload(1'b0, 13, 16'h2298);

    // main table: R2 R3 R4 R5 R6 R7 R10
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NROW; i++) begin
      #1;
      chk_cyc("R2/R3/R4/R5/R6/R7/R10 table", PROG[i][51:36], PROG[i][19],
              PROG[i][18:16], PROG[i][15:0]);
      @(negedge clk);
    end

    // R1 reset mid-run, R8 memory kept
    rst = 1'b1;
    #1 chk("R1 wr_en gated in reset", {15'd0, dbg_wr_en}, 16'h0000);
    @(negedge clk);
    #1 chk("R1 pc cleared", dbg_pc, 16'h0000);
    preload(1'b0, 0, 16'h2298);
    preload(1'b0, 1, 16'h0048);
    preload(1'b0, 2, 16'hDFFF);
    preload(1'b0, 63, 16'hD005);
    @(negedge clk);
    rst = 1'b0;
    #1 chk_cyc("R1 registers cleared", 16'h0000, 1'b1, 3'd3, 16'h0000);
    @(negedge clk);
    #1 chk_cyc("R8 data kept over reset", 16'h0002, 1'b1, 3'd1, 16'h0006);
    @(negedge clk);
    #1 chk_cyc("R6 jump far", 16'h0004, 1'b0, 3'd0, 16'h0000);
    @(negedge clk);
    #1 chk_cyc("R6 jump target low page", 16'h1FFE, 1'b0, 3'd0, 16'h0000);
    @(negedge clk);
    #1 chk_cyc("R6 page bits from successor, R2 index wrap", 16'h200A, 1'b1, 3'd6, 16'h8000);

    // R9 preload versus store
    @(negedge clk);
    rst = 1'b1;
    preload(1'b1, 10, 16'h5555);
    preload(1'b0, 0, 16'h1009);
    preload(1'b0, 1, 16'h0049);
    preload(1'b0, 2, 16'h100A);
    preload(1'b0, 3, 16'h008A);
    preload(1'b0, 4, 16'h00CB);
    preload(1'b0, 5, 16'hD005);
    @(negedge clk);
    rst = 1'b0;
    pl_en = 1'b1; pl_dmem = 1'b1; pl_addr = DAW'(9); pl_data = 16'hABCD;
    #1 chk_cyc("R9 store cycle", 16'h0000, 1'b0, 3'd0, 16'h0000);
    @(negedge clk);
    pl_en = 1'b0;
    #1 chk_cyc("R9 preload wins same word", 16'h0002, 1'b1, 3'd1, 16'hABCD);
    @(negedge clk);
    pl_en = 1'b1; pl_dmem = 1'b1; pl_addr = DAW'(11); pl_data = 16'h1111;
    #1 chk_cyc("R9 store other word", 16'h0004, 1'b0, 3'd0, 16'h0000);
    @(negedge clk);
    pl_en = 1'b0;
    #1 chk_cyc("R9 store landed", 16'h0006, 1'b1, 3'd2, 16'h0000);
    @(negedge clk);
    #1 chk_cyc("R9 preload landed", 16'h0008, 1'b1, 3'd3, 16'h1111);
    @(negedge clk);
    #1 chk_cyc("R6 self jump", 16'h000A, 1'b0, 3'd0, 16'h0000);
    @(negedge clk);
    #1 chk_cyc("R6 self jump holds", 16'h000A, 1'b0, 3'd0, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule